// File: doc/BRIEF.md
# I2C Transfer Byte Counter

This block counts down the number of bytes that remain in an I2C transfer. Software loads a 16-bit count through a byte-wide register port. The controller's bit engine then sends the block one strobe per falling SCL edge, together with START/STOP detections and the transfer direction. The block tracks where the bus is inside each 9-edge byte frame (eight data bits plus the ACK bit). It decrements the count once per byte, on the edge that matches the direction. When a frame completes with nothing left to count, it raises a sticky interrupt flag.

The count has a high-byte address and a low-byte address. A high-byte write is staged in a holding register. A low-byte write then moves both bytes into the count at once, so the controller never sees a half-written value. Reads are not staged: each read returns the live byte. Software is expected to load the count only while the controller is idle or is holding SCL low.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset, the count is 0, the interrupt flag is 0 and the bit index is 0.
- R2: The bit index rises by one on each falling-SCL strobe and returns to 0 on the strobe that follows index 8, which is the ACK edge.
- R3: A START (or repeated START) or STOP indication forces the bit index to 0. If a strobe arrives in the same cycle, it is ignored.
- R4: When receiving (direction 0), the count drops by one on the 8th falling edge of a frame, which is the strobe seen while the index is 7.
- R5: When transmitting (direction 1), the count drops by one on the 9th falling edge of a frame, which is the strobe seen while the index is 8. The 8th edge leaves the count unchanged.
- R6: A write to address 1 (high byte) changes only the holding register and leaves the count unchanged. A write to address 0 (low byte) loads the count with {held byte, written byte}.
- R7: Reads return live values. Address 0 gives count[7:0], address 1 gives count[15:8], and address 2 gives the flag in bit 0.
- R8: A decrement event while the count is 0 leaves the count at 0.
- R9: The flag sets on the 9th falling edge of a frame if the count was 0 before any decrement on that edge.
- R10: The flag is sticky. It clears only when software writes to address 2 with bit 0 = 1. If a set and a clear fall in the same cycle, the set wins.
- R11: A low-byte load in the same cycle as a decrement event takes effect, and that decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_fall | input | 1 | One-cycle strobe per falling SCL edge |
| start_det | input | 1 | START or repeated START seen |
| stop_det | input | 1 | STOP seen |
| dir_tx | input | 1 | 1 = transmitting, 0 = receiving |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 low byte, 1 high byte, 2 flag control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Live read data for reg_addr |
| count | output | 16 | Live byte count |
| cnt_flag | output | 1 | Byte-count interrupt flag |
| bit_idx | output | 4 | Falling edges seen in the current frame (0..8) |

## Verification
The embedded assertions check the invariants on every cycle: the index stays within 0..8, a frame indication zeroes the index, the count never wraps below zero, a low-byte load always wins over a decrement, a high-byte write alone leaves the count unchanged, and the flag only disappears on a clear. Some behaviour can only be shown by the bench's scenarios: that the decrement falls on edge 8 for receive but edge 9 for transmit, that the flag's zero test uses the pre-decrement value (a count of 1 on a transmit ACK edge reaches zero without setting the flag), and that reads return the staged versus live bytes.

// File: rtl/bcnt_pkg.sv
// Package: shared constants and register address codes for the byte counter.
// Assumes a byte-wide software port and a 9-edge I2C byte frame.
package bcnt_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int FRAME_BITS = 9;   // eight data bits plus ACK

    typedef enum logic [ADDR_W-1:0] {
        ADDR_LO  = 2'd0,
        ADDR_HI  = 2'd1,
        ADDR_CTL = 2'd2,
        ADDR_RSV = 2'd3
    } bcnt_addr_e;
endpackage

// File: rtl/bcnt_bitpos.sv
// Module: bcnt_bitpos
// Tracks the position inside the current I2C byte frame and decodes the
// frame edges on which the counter and the flag act.
// Assumes scl_fall is a single-cycle strobe per falling SCL edge and that
// START/STOP indications are single-cycle strobes.
module bcnt_bitpos #(
    parameter int FRAME_BITS = 9,
    parameter int IDX_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic [IDX_W-1:0] bit_idx,
    output logic             data_edge,   // last data edge (8th)
    output logic             ack_edge     // ACK edge (9th)
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(FRAME_BITS - 2);

    logic frame_rst;
    logic edge_ok;

    // Purpose: a frame indication suppresses any strobe in the same cycle.
    always_comb begin
        frame_rst = start_det | stop_det;
        edge_ok   = scl_fall & ~frame_rst;
        data_edge = edge_ok & (bit_idx == IDX_DATA);
        ack_edge  = edge_ok & (bit_idx == IDX_LAST);
    end

    // Purpose: advance, wrap after the ACK edge, or restart on START/STOP.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_rst) begin
            bit_idx <= '0;
        end else if (edge_ok) begin
            bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + IDX_W'(1);
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= IDX_LAST);  // R2

    AST_FRAME_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> (bit_idx == '0));  // R3
endmodule

// File: rtl/bcnt_regport.sv
// Module: bcnt_regport
// Decodes the byte-wide register port: stages the high byte, produces the
// 16-bit load request on a low-byte write, the flag clear request, and the
// unbuffered read data.
// Assumes at most one write per cycle and reads that sample live state.
module bcnt_regport
    import bcnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    input  logic              flag_live,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic              flag_clr,
    output logic              hi_wr,
    output logic [BYTE_W-1:0] reg_rdata
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic [HI_W-1:0] hold_q;
    bcnt_addr_e      addr;

    // Purpose: decode write strobes per address.
    always_comb begin
        addr     = bcnt_addr_e'(reg_addr);
        load_en  = reg_wr && (addr == ADDR_LO);
        hi_wr    = reg_wr && (addr == ADDR_HI);
        flag_clr = reg_wr && (addr == ADDR_CTL) && reg_wdata[0];
        load_val = {hold_q, reg_wdata};
    end

    // Purpose: stage the high byte until the low byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hi_wr) begin
            hold_q <= HI_W'(reg_wdata);
        end
    end

    // Purpose: unbuffered read of the live count bytes and the flag.
    always_comb begin
        case (addr)
            ADDR_LO:  reg_rdata = cnt_live[BYTE_W-1:0];
            ADDR_HI:  reg_rdata = BYTE_W'(cnt_live[CNT_W-1:BYTE_W]);
            ADDR_CTL: reg_rdata = {{(BYTE_W-1){1'b0}}, flag_live};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcnt_core.sv
// Module: bcnt_core
// Holds the byte count. A software load overrides a decrement in the same
// cycle; the count saturates at zero.
// Assumes dec_req is already qualified by direction and frame position.
module bcnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);
    // Purpose: flag a zero count for the flag logic and the saturation.
    always_comb cnt_zero = (cnt_q == '0);

    // Purpose: load, decrement or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (dec_req && !cnt_zero) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_en) |=> (cnt_q == '0));  // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_q == $past(load_val)));  // R11

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && !load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));  // R4
endmodule

// File: rtl/bcnt_flag.sv
// Module: bcnt_flag
// Sticky byte-count interrupt flag. Set wins over a same-cycle clear.
// Assumes set_req already holds the pre-decrement zero test.
module bcnt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_q
);
    // Purpose: set on request, otherwise clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_req) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);  // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_q);  // R9
endmodule

// File: rtl/xfer_byte_counter.sv
// Module: xfer_byte_counter (top)
// I2C transfer byte counter: frame position tracking, direction-dependent
// decrement, staged two-byte load and sticky completion flag.
// Assumes software loads the count only while the bus is idle or stretched.
module xfer_byte_counter
    import bcnt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              dir_tx,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  count,
    output logic              cnt_flag,
    output logic [IDX_W-1:0]  bit_idx
);
    logic             data_edge;
    logic             ack_edge;
    logic             dec_evt;
    logic             set_evt;
    logic             load_en;
    logic [CNT_W-1:0] load_val;
    logic             flag_clr;
    logic             hi_wr;
    logic             cnt_zero;

    bcnt_bitpos #(.FRAME_BITS(FRAME_BITS), .IDX_W(IDX_W)) u_bitpos (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bit_idx   (bit_idx),
        .data_edge (data_edge),
        .ack_edge  (ack_edge)
    );

    // Purpose: pick the decrement edge by direction; zero test before decrement.
    always_comb begin
        dec_evt = dir_tx ? ack_edge : data_edge;
        set_evt = ack_edge & cnt_zero;
    end

    bcnt_regport #(.CNT_W(CNT_W)) u_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_live  (count),
        .flag_live (cnt_flag),
        .load_en   (load_en),
        .load_val  (load_val),
        .flag_clr  (flag_clr),
        .hi_wr     (hi_wr),
        .reg_rdata (reg_rdata)
    );

    bcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (load_val),
        .dec_req  (dec_evt),
        .cnt_q    (count),
        .cnt_zero (cnt_zero)
    );

    bcnt_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_evt),
        .clr_req (flag_clr),
        .flag_q  (cnt_flag)
    );

    AST_HIGH_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !dec_evt) |=> $stable(count));  // R6
endmodule

// File: tb/xfer_byte_counter_tb.sv
module xfer_byte_counter_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       req;
        int          due;
        bit          chk_state;
        logic [15:0] cnt;
        logic        flg;
        logic [3:0]  idx;
        logic [7:0]  rd;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_fall = 1'b0, start_det = 1'b0, stop_det = 1'b0, dir_tx = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] count;
    logic        cnt_flag;
    logic [3:0]  bit_idx;

    item_t q[$];
    int    cyc_n = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    xfer_byte_counter u_dut (
        .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .dir_tx(dir_tx), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
        .cnt_flag(cnt_flag), .bit_idx(bit_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    // Driver: apply one cycle of stimulus; returns just after the edge.
    task automatic drive(input logic f, input logic st, input logic sp, input logic tx,
                         input logic wr, input logic [1:0] a, input logic [7:0] d);
        scl_fall = f; start_det = st; stop_det = sp; dir_tx = tx;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        drive(0, 0, 0, dir_tx, 0, reg_addr, 8'h00);
    endtask

    task automatic fall(input logic tx);
        drive(1, 0, 0, tx, 0, 2'd0, 8'h00);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        drive(0, 0, 0, dir_tx, 1, a, d);
    endtask

    // Expect state after the edge just passed.
    task automatic exp_state(input string r, input logic [15:0] c, input logic fl,
                             input logic [3:0] i);
        item_t it;
        it.req = r; it.due = cyc_n; it.chk_state = 1'b1;
        it.cnt = c; it.flg = fl; it.idx = i; it.rd = 8'h00;
        q.push_back(it);
    endtask

    // Expect read data for address a, checked within this cycle.
    task automatic exp_read(input string r, input logic [1:0] a, input logic [7:0] v);
        item_t it;
        scl_fall = 0; start_det = 0; stop_det = 0; reg_wr = 0; reg_addr = a;
        it.req = r; it.due = cyc_n; it.chk_state = 1'b0;
        it.cnt = '0; it.flg = 1'b0; it.idx = '0; it.rd = v;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    // Monitor: pop due items at the falling edge and compare.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc_n) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (it.chk_state) begin
                if (count !== it.cnt || cnt_flag !== it.flg || bit_idx !== it.idx) begin
                    n_err++;
                    $display("FAIL %s: count=%h flag=%b idx=%0d expected count=%h flag=%b idx=%0d",
                             it.req, count, cnt_flag, bit_idx, it.cnt, it.flg, it.idx);
                end
            end else if (reg_rdata !== it.rd) begin
                n_err++;
                $display("FAIL %s: rdata=%h expected %h", it.req, reg_rdata, it.rd);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_state("R1 reset", 16'h0000, 0, 0);
        idle();

        // R6: staged high byte, then joint load
        wr_reg(2'd1, 8'h01);
        exp_state("R6 high write staged", 16'h0000, 0, 0);
        wr_reg(2'd0, 8'h02);
        exp_state("R6 low write loads", 16'h0102, 0, 0);
        exp_read("R7 read high", 2'd1, 8'h01);
        exp_read("R7 read low", 2'd0, 8'h02);

        // R4 / R2: receive frame
        for (int k = 1; k <= 7; k++) fall(0);
        exp_state("R4 unchanged before 8th edge", 16'h0102, 0, 7);
        fall(0);
        exp_state("R4 rx decrement on 8th edge", 16'h0101, 0, 8);
        fall(0);
        exp_state("R2 wrap after ACK edge", 16'h0101, 0, 0);

        // R5: transmit frame
        for (int k = 1; k <= 8; k++) fall(1);
        exp_state("R5 no decrement on 8th edge", 16'h0101, 0, 8);
        fall(1);
        exp_state("R5 tx decrement on 9th edge", 16'h0100, 0, 0);

        // R3: frame restart
        for (int k = 1; k <= 3; k++) fall(1);
        exp_state("R2 advance", 16'h0100, 0, 3);
        drive(0, 1, 0, 1, 0, 2'd0, 8'h00);
        exp_state("R3 START resets index", 16'h0100, 0, 0);
        fall(1);
        drive(1, 0, 1, 1, 0, 2'd0, 8'h00);
        exp_state("R3 STOP with strobe resets index", 16'h0100, 0, 0);

        // R9 / R8: count 1 then transmit two frames
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h01);
        exp_state("R6 load 0001", 16'h0001, 0, 0);
        for (int k = 1; k <= 9; k++) fall(1);
        exp_state("R9 pre-decrement value nonzero, no flag", 16'h0000, 0, 0);
        for (int k = 1; k <= 9; k++) fall(1);
        exp_state("R8 hold at zero, R9 flag set", 16'h0000, 1, 0);
        exp_read("R7 read flag", 2'd2, 8'h01);

        // R10: sticky flag and clear
        wr_reg(2'd2, 8'h00);
        exp_state("R10 write without bit0 keeps flag", 16'h0000, 1, 0);
        wr_reg(2'd2, 8'h01);
        exp_state("R10 clear", 16'h0000, 0, 0);
        for (int k = 1; k <= 8; k++) fall(0);
        drive(1, 0, 0, 0, 1, 2'd2, 8'h01);
        exp_state("R10 set wins over clear", 16'h0000, 1, 0);

        // R11: load beats decrement (held byte is 00)
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h10);
        exp_state("R6 load 0010", 16'h0010, 0, 0);
        for (int k = 1; k <= 7; k++) fall(0);
        drive(1, 0, 0, 0, 1, 2'd0, 8'h55);
        exp_state("R11 load wins over rx decrement", 16'h0055, 0, 8);
        drive(0, 0, 1, 0, 0, 2'd0, 8'h00);
        exp_state("R3 STOP mid-frame", 16'h0055, 0, 0);

        repeat (3) idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule